// File: doc/BRIEF.md
# Serial Converter Result Readout Port

This block is the device-side serial port through which a host reads conversion results out of a converter. Results come from an internal producer over a valid/ready stream. The port accepts a result into a shadow register and announces it on the shared serial output line: the line reads low for "result waiting" and high for "nothing new". The host then clocks the 24-bit word out through a four-wire serial interface. Chip select is active low. The serial clock idles high. The falling edge launches output bits, and the rising edge samples input bits. The one output line carries both the data word and the ready indication.

A configuration byte chooses one of three conversion modes and a tail rule. The modes are single, continuous and continuous-read. The tail rule decides whether the line returns to the ready function after the last bit, or keeps the least significant bit until chip select rises. In single and continuous modes the host sends a read command and may repeat a read of the same word. In continuous-read mode the word comes out with no command as soon as chip select falls, but only once per result. All pins are sampled in the system clock domain, which must run at least eight times faster than the serial clock.

Stream rules: the producer's `res_valid`/`res_data` are taken on any clock where `res_ready` is high. The port drops `res_ready` only while a word is being shifted out and one newer result has already arrived during that shift. A producer must then hold its result until `res_ready` returns.

Top module: `adc_serial_readout`

## Requirements
- R1: After reset, `dout_oe` is 0, `res_ready` is 1, `conv_mode` is 00 (single), the tail rule is "revert to ready", and the ready indication is high.
- R2: A result taken on the stream drives the ready indication low from the next clock. The line shows this value whenever chip select is low and no data bit is being driven.
- R3: In single or continuous mode, a command byte of 8'hC0 (MSB first) starts a read. The 24-bit word is then launched on the next 24 serial-clock falling edges, bit 23 first and bit 0 last.
- R4: Once the rising edge of the final data bit has passed, the ready indication returns high, unless a newer result was taken during that read.
- R5: In single and continuous modes, a second read with no new result returns the same word, and the ready indication stays high during its command byte.
- R6: In continuous-read mode (`conv_mode` 10), the word is shifted out at once if chip select falls while the ready indication is low. If it is high, the line stays high for the whole frame, so no word is replayed. The read command is ignored in this mode.
- R7: With the tail rule bit clear, the line shows the ready indication after the final rising edge.
- R8: With the tail rule bit set, the line keeps bit 0 of the word after the final rising edge, until chip select rises.
- R9: A result that arrives during a read leaves the word in flight unchanged and keeps the ready indication low after that read. The next read returns the new result.
- R10: While a read is in progress and a newer result is already pending, `res_ready` is 0, and an offered result is not taken.
- R11: `dout_oe` is 1 while chip select is low and 0 once it has been high for a few clocks.
- R12: Command 8'h40 followed by a configuration byte writes the configuration. Bits [1:0] select the mode: 00 single, 01 continuous, 10 continuous-read, and 11 acts as single. Bit 2 is the tail rule. Any other command byte is ignored for the rest of the frame and changes nothing.
- R13: A read cut short by chip select rising before the last bit leaves the ready indication unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Shared data / ready line |
| dout_oe | output | 1 | Output enable for `dout` (tri-state control) |
| res_valid | input | 1 | Producer result valid |
| res_data | input | 24 | Producer result word |
| res_ready | output | 1 | Port can take a result |
| conv_mode | output | 2 | Current conversion mode for the producer |

## Verification
The bench walks a single one through all 24 bit positions. A port that swapped bit order or dropped a shift would return a moved bit, and one that never cleared ready would show zeros in the second command byte. Continuous-read frames are repeated with no new result in between, so a port that replays the word fails. The test is also run with both tail rules, which catches a line that reverts too early or holds too long. One result is injected mid-read and a second is offered behind it. A port that reloaded its shift register early would corrupt the word in flight, and one that lost the pending flag would raise ready. Aborted reads and reserved or unknown configuration codes are also covered, since a port that completed an aborted read or decoded junk would change its later behaviour.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_CONT   = 2'b01,
    MODE_CREAD  = 2'b10
  } conv_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_WDATA,
    PH_RDATA,
    PH_TAIL,
    PH_SKIP
  } phase_e;

  localparam int CFG_W = 3;
endpackage

// File: rtl/adc_rd_pin_sync.sv
module adc_rd_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  output logic cs_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic din_s
);
  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] sk_q;
  logic [STAGES-1:0] di_q;
  logic              sk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= '1;
      sk_q    <= '1;
      di_q    <= '0;
      sk_prev <= 1'b1;
    end else begin
      cs_q    <= {cs_q[STAGES-2:0], cs_n};
      sk_q    <= {sk_q[STAGES-2:0], sclk};
      di_q    <= {di_q[STAGES-2:0], din};
      sk_prev <= sk_q[STAGES-1];
    end
  end

  assign cs_act    = ~cs_q[STAGES-1];
  assign sclk_rise = sk_q[STAGES-1] & ~sk_prev;
  assign sclk_fall = ~sk_q[STAGES-1] & sk_prev;
  assign din_s     = di_q[STAGES-1];
endmodule

// File: rtl/adc_rd_frame_ctl.sv
module adc_rd_frame_ctl
  import adc_rd_pkg::*;
#(
  parameter int          DW       = 24,
  parameter int          CW       = 8,
  parameter logic [CW-1:0] CMD_RD = 8'hC0,
  parameter logic [CW-1:0] CMD_WR = 8'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             din_s,
  input  conv_mode_e       mode,
  input  logic             rdy_n,
  output phase_e           phase,
  output logic             load,
  output logic             read_done,
  output logic             shift_evt,
  output logic             cfg_we,
  output logic [CFG_W-1:0] cfg_field
);
  localparam int MAXB = (DW > CW) ? DW : CW;
  localparam int CNTW = $clog2(MAXB);

  logic [CNTW-1:0] cnt;
  logic [CW-1:0]   sreg;
  logic [CW-1:0]   byte_next;
  logic            byte_last;
  logic            word_last;
  logic            cread_go;
  logic            rd_cmd;

  assign byte_next = {sreg[CW-2:0], din_s};
  assign byte_last = sclk_rise && (cnt == CNTW'(CW-1));
  assign word_last = sclk_rise && (cnt == CNTW'(DW-1));
  assign cread_go  = (phase == PH_IDLE) && cs_act && (mode == MODE_CREAD) && !rdy_n;
  assign rd_cmd    = (phase == PH_CMD) && byte_last && (byte_next == CMD_RD) &&
                     (mode != MODE_CREAD);

  assign load      = cread_go || rd_cmd;
  assign read_done = (phase == PH_RDATA) && word_last;
  assign shift_evt = (phase == PH_RDATA) && sclk_fall;
  assign cfg_we    = (phase == PH_WDATA) && byte_last;
  assign cfg_field = byte_next[CFG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      sreg  <= '0;
    end else if (!cs_act) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt   <= '0;
          phase <= cread_go ? PH_RDATA : PH_CMD;
        end
        PH_CMD: if (sclk_rise) begin
          sreg <= byte_next;
          cnt  <= cnt + 1'b1;
          if (byte_last) begin
            cnt <= '0;
            if (byte_next == CMD_WR)  phase <= PH_WDATA;
            else if (rd_cmd)          phase <= PH_RDATA;
            else                      phase <= PH_SKIP;
          end
        end
        PH_WDATA: if (sclk_rise) begin
          sreg <= byte_next;
          cnt  <= cnt + 1'b1;
          if (byte_last) phase <= PH_SKIP;
        end
        PH_RDATA: if (sclk_rise) begin
          cnt <= cnt + 1'b1;
          if (word_last) phase <= PH_TAIL;
        end
        default: ;
      endcase
    end
  end

  // R3: one frame event at a time
  assert_one_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load, read_done, cfg_we}));

  // R6: a continuous-read frame never starts on a stale result
  assert_no_replay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode == MODE_CREAD) |-> !rdy_n);
endmodule

// File: rtl/adc_rd_cfg.sv
module adc_rd_cfg
  import adc_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_field,
  output conv_mode_e       mode,
  output logic             cs_hold
);
  conv_mode_e mode_dec;

  always_comb begin
    unique case (cfg_field[1:0])
      2'b01:   mode_dec = MODE_CONT;
      2'b10:   mode_dec = MODE_CREAD;
      default: mode_dec = MODE_SINGLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_SINGLE;
      cs_hold <= 1'b0;
    end else if (cfg_we) begin
      mode    <= mode_dec;
      cs_hold <= cfg_field[2];
    end
  end

  // R12: configuration only moves on a write
  assert_cfg_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(mode) && $stable(cs_hold)));
endmodule

// File: rtl/adc_rd_result_store.sv
module adc_rd_result_store #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  output logic          res_ready,
  input  logic          busy,
  input  logic          load,
  input  logic          read_done,
  output logic [DW-1:0] shadow,
  output logic          rdy_n
);
  logic pend;
  logic acc;

  assign res_ready = !(busy && pend);
  assign acc       = res_valid && res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      pend   <= 1'b0;
      rdy_n  <= 1'b1;
    end else begin
      if (acc) shadow <= res_data;

      if (load)             pend <= acc;
      else if (acc && busy) pend <= 1'b1;

      if (read_done)  rdy_n <= !(pend || acc);
      else if (acc)   rdy_n <= 1'b0;
    end
  end

  // R2: a taken result lowers ready on the next clock
  assert_ready_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !rdy_n);

  // R4: a finished read with nothing newer raises ready
  assert_ready_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (read_done && !pend && !acc) |=> rdy_n);

  // R10: a result offered behind a pending one is not taken
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pend && res_valid && !read_done) |=> $stable(shadow));
endmodule

// File: rtl/adc_rd_shift_out.sv
module adc_rd_shift_out #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] shadow,
  input  logic          shift_evt,
  input  logic          in_rdata,
  input  logic          in_tail,
  input  logic          cs_hold,
  input  logic          rdy_n,
  input  logic          cs_act,
  output logic          dout,
  output logic          dout_oe
);
  logic [DW-1:0] sh;
  logic          bit_q;
  logic          data_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_q   <= 1'b1;
      data_on <= 1'b0;
    end else if (load) begin
      sh      <= shadow;
      data_on <= 1'b0;
    end else if (shift_evt) begin
      bit_q   <= sh[DW-1];
      sh      <= {sh[DW-2:0], 1'b0};
      data_on <= 1'b1;
    end
  end

  always_comb begin
    if ((in_rdata && data_on) || (in_tail && cs_hold)) dout = bit_q;
    else                                               dout = rdy_n;
  end

  assign dout_oe = cs_act;

  // R8: with the hold rule the final bit stays put through the tail
  assert_tail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tail && cs_hold && $past(in_tail) && $past(cs_hold)) |-> $stable(dout));
endmodule

// File: rtl/adc_serial_readout.sv
module adc_serial_readout
  import adc_rd_pkg::*;
#(
  parameter int DW          = 24,
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          din,
  output logic          dout,
  output logic          dout_oe,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  output logic          res_ready,
  output logic [1:0]    conv_mode
);
  logic             cs_act;
  logic             sclk_rise;
  logic             sclk_fall;
  logic             din_s;
  phase_e           phase;
  logic             load;
  logic             read_done;
  logic             shift_evt;
  logic             cfg_we;
  logic [CFG_W-1:0] cfg_field;
  conv_mode_e       mode;
  logic             cs_hold;
  logic [DW-1:0]    shadow;
  logic             rdy_n;
  logic             in_rdata;
  logic             in_tail;

  assign in_rdata  = (phase == PH_RDATA);
  assign in_tail   = (phase == PH_TAIL);
  assign conv_mode = mode;

  adc_rd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din_s(din_s)
  );

  adc_rd_frame_ctl #(.DW(DW), .CW(CW)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .din_s(din_s), .mode(mode), .rdy_n(rdy_n),
    .phase(phase), .load(load), .read_done(read_done), .shift_evt(shift_evt),
    .cfg_we(cfg_we), .cfg_field(cfg_field)
  );

  adc_rd_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
    .mode(mode), .cs_hold(cs_hold)
  );

  adc_rd_result_store #(.DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .res_ready(res_ready), .busy(in_rdata), .load(load), .read_done(read_done),
    .shadow(shadow), .rdy_n(rdy_n)
  );

  adc_rd_shift_out #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shadow(shadow), .shift_evt(shift_evt),
    .in_rdata(in_rdata), .in_tail(in_tail), .cs_hold(cs_hold), .rdy_n(rdy_n),
    .cs_act(cs_act), .dout(dout), .dout_oe(dout_oe)
  );

  // R11: the line is driven only inside a frame
  assert_oe_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !cs_act) |-> !dout_oe);
endmodule

// File: tb/adc_serial_readout_tb.sv
module adc_serial_readout_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic        dout;
  logic        dout_oe;
  logic        res_valid = 1'b0;
  logic [23:0] res_data = '0;
  logic        res_ready;
  logic [1:0]  conv_mode;

  int vec = 0;
  int bad = 0;
  logic        oe_mid;
  logic [31:0] miso;
  logic        tail;
  logic [23:0] d;
  logic [23:0] d2;
  logic [23:0] d3;

  always #4 clk = ~clk;

  adc_serial_readout u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .res_valid(res_valid), .res_data(res_data),
    .res_ready(res_ready), .conv_mode(conv_mode)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [23:0] v);
    @(negedge clk);
    while (!res_ready) @(negedge clk);
    res_valid = 1'b1;
    res_data  = v;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] mosi, input int n, output logic [31:0] so, output logic tl);
    so = '0;
    @(negedge clk);
    cs_n = 1'b0;
    #48;
    oe_mid = dout_oe;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0;
      din  = mosi[i];
      #48;
      so[i] = dout;
      sclk = 1'b1;
      #48;
    end
    tl   = dout;
    cs_n = 1'b1;
    din  = 1'b0;
    #48;
  endtask

  task automatic cfg(input logic [7:0] v);
    logic [31:0] s;
    logic t;
    xfer({16'h0, 8'h40, v}, 16, s, t);
  endtask

  initial begin
    #1600000;
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout_oe == 1'b0, "R1 oe", 32'(dout_oe), 0);
    chk(res_ready == 1'b1, "R1 res_ready", 32'(res_ready), 1);
    chk(conv_mode == 2'b00, "R1 mode", 32'(conv_mode), 0);

    // idle frame with an unknown command: all ready-high
    xfer(32'h0, 32, miso, tail);
    chk(miso == 32'hFFFF_FFFF, "R1 R12 ready high, junk command", miso, 32'hFFFF_FFFF);
    chk(oe_mid == 1'b1, "R11 oe in frame", 32'(oe_mid), 1);
    chk(dout_oe == 1'b0, "R11 oe after frame", 32'(dout_oe), 0);

    cfg(8'h01);
    chk(conv_mode == 2'b01, "R12 continuous", 32'(conv_mode), 1);

    // walking one, revert-to-ready tail
    for (int i = 0; i < 24; i++) begin
      d = 24'(1) << i;
      push(d);
      xfer({8'hC0, 24'h0}, 32, miso, tail);
      chk(miso[31:24] == 8'h00, "R2 ready low in command", 32'(miso[31:24]), 0);
      chk(miso[23:0] == d, "R3 word msb first", 32'(miso[23:0]), 32'(d));
      chk(tail == 1'b1, "R7 revert after last edge", 32'(tail), 1);
      xfer({8'hC0, 24'h0}, 32, miso, tail);
      chk(miso[31:24] == 8'hFF, "R4 ready high after read", 32'(miso[31:24]), 32'hFF);
      chk(miso[23:0] == d, "R5 repeat read", 32'(miso[23:0]), 32'(d));
    end

    // single mode with LSB hold
    cfg(8'h04);
    chk(conv_mode == 2'b00, "R12 single", 32'(conv_mode), 0);
    for (int k = 0; k < 8; k++) begin
      d = 24'(k * 185763) ^ 24'hA5A5A5;
      push(d);
      xfer({8'hC0, 24'h0}, 32, miso, tail);
      chk(miso[23:0] == d, "R3 word single", 32'(miso[23:0]), 32'(d));
      chk(tail == d[0], "R8 hold lsb", 32'(tail), 32'(d[0]));
      chk(dout_oe == 1'b0, "R11 oe released", 32'(dout_oe), 0);
    end

    cfg(8'h03);
    chk(conv_mode == 2'b00, "R12 reserved code", 32'(conv_mode), 0);
    xfer({8'h7E, 8'h02, 16'h0}, 32, miso, tail);
    chk(conv_mode == 2'b00, "R12 unknown command ignored", 32'(conv_mode), 0);
    chk(miso == 32'hFFFF_FFFF, "R12 line shows ready", miso, 32'hFFFF_FFFF);

    // continuous-read
    cfg(8'h02);
    chk(conv_mode == 2'b10, "R12 continuous-read", 32'(conv_mode), 2);
    for (int k = 0; k < 6; k++) begin
      d = 24'(k * 699053 + 4660);
      push(d);
      xfer(32'h0, 24, miso, tail);
      chk(miso[23:0] == d, "R6 word without command", 32'(miso[23:0]), 32'(d));
      chk(tail == 1'b1, "R7 revert in continuous-read", 32'(tail), 1);
      xfer(32'h0, 24, miso, tail);
      chk(miso[23:0] == 24'hFFFFFF, "R6 no replay", 32'(miso[23:0]), 32'hFFFFFF);
    end
    xfer({8'hC0, 24'h0}, 32, miso, tail);
    chk(miso == 32'hFFFF_FFFF, "R6 read command refused", miso, 32'hFFFF_FFFF);
    cfg(8'h06);
    d = 24'h3C5A97;
    push(d);
    xfer(32'h0, 24, miso, tail);
    chk(miso[23:0] == d, "R6 word with hold", 32'(miso[23:0]), 32'(d));
    chk(tail == d[0], "R8 hold lsb continuous-read", 32'(tail), 32'(d[0]));

    // mid-read arrival and back-pressure
    cfg(8'h01);
    d  = 24'h123456;
    d2 = 24'hABCDEF;
    d3 = 24'h0F0F0F;
    push(d);
    fork
      xfer({8'hC0, 24'h0}, 32, miso, tail);
      begin
        #1200;
        push(d2);
        chk(res_ready == 1'b0, "R10 ready drops", 32'(res_ready), 0);
        res_valid = 1'b1;
        res_data  = d3;
        repeat (2) @(negedge clk);
        res_valid = 1'b0;
      end
    join
    chk(miso[23:0] == d, "R9 word in flight intact", 32'(miso[23:0]), 32'(d));
    xfer({8'hC0, 24'h0}, 32, miso, tail);
    chk(miso[31:24] == 8'h00, "R9 ready stays low", 32'(miso[31:24]), 0);
    chk(miso[23:0] == d2, "R10 blocked result not taken", 32'(miso[23:0]), 32'(d2));

    // aborted read
    d = 24'h5A5A01;
    push(d);
    xfer({16'h0, 8'hC0, 8'h00}, 16, miso, tail);
    xfer({8'hC0, 24'h0}, 32, miso, tail);
    chk(miso[31:24] == 8'h00, "R13 abort keeps ready", 32'(miso[31:24]), 0);
    chk(miso[23:0] == d, "R13 word after abort", 32'(miso[23:0]), 32'(d));

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule